// File: doc/BRIEF.md
# Configurable SPI Word Shift Engine

This block is the serial core of an SPI master. It moves one word of 1 to 32 bits at a time. Bits go out on MOSI and come in from MISO, most significant bit first. A registered command word sets four things: the serial clock's resting level, which SCLK edge samples data, the word length, and how the four chip-select lines behave. The command is taken up only while the engine is idle and is held for the whole of a word.

Words come from an upstream FIFO through a valid/pop pair. Received words go to a downstream FIFO through a single-cycle push strobe. A `clk_en` tick paces the serial clock, and each tick moves SCLK by one half-period. The controller around the block raises `go` to run words back to back.

Command word layout (bit positions): [4:0] word length minus one; [5] sample-edge select; [7:6] resting clock code; [8] transmit enable; [9] receive enable; [10] hardware-timed select; [11] software select level; [12] select polarity invert; [13] select line enable; [15:14] device index.

Top module: `spi_word_shifter`

## Requirements
- R1: A word has N = cmd[4:0] + 1 bits. MOSI carries the low N bits of `tx_data`, MSB first.
- R2: With cmd[5] = 0, both ends sample data on rising SCLK edges. With cmd[5] = 1, they sample on falling edges. The first bit is valid on MOSI before the first sampling edge.
- R3: While idle, SCLK rests at cmd[7:6] decoded as follows: codes 0 and 2 give low, codes 1 and 3 give high. SCLK returns to this level when a word ends.
- R4: When cmd[13] = 1, only the line at index cmd[15:14] of `cs_o` can be asserted. When cmd[13] = 0, no line is asserted. At no time is more than one line asserted.
- R5: With cmd[10] = 1, the selected line is asserted exactly while `busy` is high. With cmd[10] = 0, the selected line is asserted when cmd[11] = 1.
- R6: The asserted level of a select line is low when cmd[12] = 0 and high when cmd[12] = 1. Lines that are not asserted sit at the opposite level.
- R7: With cmd[8] = 1, a word starts only when both `go` and `tx_valid` are high, and `tx_pop` pulses in the start cycle. With cmd[8] = 0, no pop occurs and MOSI is 0 during the word.
- R8: With cmd[9] = 1, `rx_push` pulses once per word. It carries the N received bits right-justified in `rx_data`, with the upper bits at zero. With cmd[9] = 0, nothing is pushed.
- R9: After reset, SCLK is low, all select lines are high, and `busy`, `word_done`, `tx_pop` and `rx_push` are low.
- R10: `busy` rises the cycle after the start cycle. `word_done` is a one-cycle pulse while `busy` is low. With `clk_en` held high, `word_done` is seen 2N+1 cycles after the start cycle.
- R11: Each `clk_en` tick during a word toggles SCLK once. A word has exactly 2N edges, and SCLK holds between ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Half-period tick for SCLK |
| go | input | 1 | Allow a new word to start |
| cmd_word | input | 16 | Command word, taken up while idle |
| tx_valid | input | 1 | Upstream FIFO has a word |
| tx_data | input | 32 | Word to transmit (low N bits used) |
| tx_pop | output | 1 | Consume the upstream word |
| miso | input | 1 | Serial data in |
| rx_push | output | 1 | Push `rx_data` downstream |
| rx_data | output | 32 | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | 4 | Chip-select lines |
| busy | output | 1 | Word in progress |
| word_done | output | 1 | One-cycle end-of-word pulse |

## Verification
The assertions assume two things about the inputs. First, `cmd_word` may change at any time, but the engine only observes it through its idle-time register. Second, `clk_en` may have any duty pattern. The bench changes the command only between words and waits two cycles for it to settle. It drives MISO as a slave would, changing it only after a sampling edge has been seen. It varies the `clk_en` divider from 1 to 3 so that SCLK stays stable across tick gaps. Cycle-exact timing is checked only when `clk_en` is held high.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned NUM_CS = 4;
  localparam int unsigned LEN_W  = $clog2(DATA_W);
  localparam int unsigned IDX_W  = $clog2(NUM_CS);
  localparam int unsigned EDGE_W = LEN_W + 2;
  localparam int unsigned CMD_W  = LEN_W + 9 + IDX_W;

  typedef struct packed {
    logic [IDX_W-1:0] cs_index;
    logic             cs_sel_en;
    logic             cs_invert;
    logic             cs_level;
    logic             cs_hw;
    logic             rx_en;
    logic             tx_en;
    logic [1:0]       idle_code;
    logic             smp_fall;
    logic [LEN_W-1:0] len_m1;
  } shift_cfg_t;

  // Resting SCLK level: codes 1 and 3 are high, 0 and 2 are low.
  function automatic logic idle_level(input logic [1:0] code);
    return (code == 2'd1) || (code == 2'd3);
  endfunction

  // Sampling happens on the leading edge when the leading edge direction
  // matches the requested sampling direction.
  function automatic logic sample_leading(input logic idle_hi, input logic smp_fall);
    return idle_hi == smp_fall;
  endfunction

  // Total SCLK edges in a word: two per bit.
  function automatic logic [EDGE_W-1:0] edge_total(input logic [LEN_W-1:0] lm1);
    return EDGE_W'(({1'b0, lm1} + 1'b1)) << 1;
  endfunction

  function automatic logic edge_is_sample(input logic lead, input logic [EDGE_W-1:0] e);
    return lead ? e[0] : ~e[0];
  endfunction

  function automatic logic edge_is_shift(input logic lead, input logic [EDGE_W-1:0] e);
    return lead ? ~e[0] : (e[0] && (e != EDGE_W'(1)));
  endfunction

  function automatic logic [NUM_CS-1:0] cs_onehot(input logic en, input logic [IDX_W-1:0] idx);
    return en ? (NUM_CS'(1) << idx) : '0;
  endfunction

endpackage

// File: rtl/spi_edge_seq.sv
module spi_edge_seq
  import spi_shift_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             start,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             idle_lvl,
  input  logic             smp_fall,
  output logic             busy,
  output logic             sclk,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             word_fin
);

  logic              active_q;
  logic [EDGE_W-1:0] ecnt_q;
  logic [EDGE_W-1:0] e_next;
  logic              tick_act;
  logic              lead;

  assign lead       = sample_leading(idle_lvl, smp_fall);
  assign e_next     = ecnt_q + 1'b1;
  assign tick_act   = active_q && clk_en;
  assign sample_stb = tick_act && edge_is_sample(lead, e_next);
  assign shift_stb  = tick_act && edge_is_shift(lead, e_next);
  assign word_fin   = tick_act && (e_next == edge_total(len_m1));
  assign busy       = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ecnt_q   <= '0;
      sclk     <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      ecnt_q   <= '0;
      sclk     <= idle_lvl;
    end else if (tick_act) begin
      ecnt_q <= e_next;
      sclk   <= ~sclk;
      if (word_fin) active_q <= 1'b0;
    end else if (!active_q) begin
      sclk <= idle_lvl;
    end
  end

endmodule

// File: rtl/spi_shift_data.sv
module spi_shift_data
  import spi_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  input  logic              sample_stb,
  input  logic              shift_stb,
  input  logic              word_fin,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_push
);

  logic [DATA_W-1:0] tx_sh_q;

  // The current bit always sits at the word's top position.
  assign mosi = tx_sh_q[len_m1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
    end else if (start) begin
      tx_sh_q <= tx_en ? tx_data : '0;
    end else if (shift_stb) begin
      tx_sh_q <= tx_sh_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
    end else if (start) begin
      rx_data <= '0;
    end else if (sample_stb) begin
      rx_data <= {rx_data[DATA_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_push <= 1'b0;
    else        rx_push <= word_fin && rx_en;
  end

endmodule

// File: rtl/spi_cs_ctl.sv
module spi_cs_ctl
  import spi_shift_pkg::*;
(
  input  logic             busy,
  input  logic             cs_hw,
  input  logic             cs_level,
  input  logic             cs_invert,
  input  logic             cs_sel_en,
  input  logic [IDX_W-1:0] cs_index,
  output logic [NUM_CS-1:0] cs_o
);

  logic              want_assert;
  logic [NUM_CS-1:0] sel;

  assign want_assert = cs_hw ? busy : cs_level;
  assign sel         = cs_onehot(cs_sel_en, cs_index);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_o[i] = (sel[i] && want_assert) ? cs_invert : ~cs_invert;
  end

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter
  import spi_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              go,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              miso,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_o,
  output logic              busy,
  output logic              word_done
);

  shift_cfg_t cfg_q;
  logic       start_w;
  logic       idle_lvl;
  logic       sample_stb;
  logic       shift_stb;
  logic       word_fin;

  assign start_w  = !busy && go && (!cfg_q.tx_en || tx_valid);
  assign tx_pop   = start_w && cfg_q.tx_en;
  assign idle_lvl = idle_level(cfg_q.idle_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cfg_q <= '0;
    else if (!busy && !start_w) cfg_q <= shift_cfg_t'(cmd_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_done <= 1'b0;
    else        word_done <= word_fin;
  end

  spi_edge_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .start      (start_w),
    .len_m1     (cfg_q.len_m1),
    .idle_lvl   (idle_lvl),
    .smp_fall   (cfg_q.smp_fall),
    .busy       (busy),
    .sclk       (sclk),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .word_fin   (word_fin)
  );

  spi_shift_data u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_w),
    .len_m1     (cfg_q.len_m1),
    .tx_en      (cfg_q.tx_en),
    .rx_en      (cfg_q.rx_en),
    .tx_data    (tx_data),
    .miso       (miso),
    .sample_stb (sample_stb),
    .shift_stb  (shift_stb),
    .word_fin   (word_fin),
    .mosi       (mosi),
    .rx_data    (rx_data),
    .rx_push    (rx_push)
  );

  spi_cs_ctl u_cs (
    .busy      (busy),
    .cs_hw     (cfg_q.cs_hw),
    .cs_level  (cfg_q.cs_level),
    .cs_invert (cfg_q.cs_invert),
    .cs_sel_en (cfg_q.cs_sel_en),
    .cs_index  (cfg_q.cs_index),
    .cs_o      (cs_o)
  );

endmodule

// File: rtl/spi_word_shifter_chk.sv
module spi_word_shifter_chk
  import spi_shift_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en,
  input logic              busy,
  input logic              sclk,
  input logic              mosi,
  input logic              tx_pop,
  input logic              tx_valid,
  input logic              rx_push,
  input logic              word_done,
  input logic [NUM_CS-1:0] cs_o,
  input logic              tx_en,
  input logic              rx_en,
  input logic              cs_invert,
  input logic              idle_lvl,
  input logic              sample_stb,
  input logic              shift_stb
);

  assert_idle_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (sclk == idle_lvl));

  assert_cs_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o ^ {NUM_CS{~cs_invert}}));

  assert_pop_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_en && tx_valid && !busy));

  assert_mosi_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_en) |-> !mosi);

  assert_push_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> rx_en);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !busy);

  assert_tick_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clk_en) |=> $stable(sclk));

  assert_edge_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && shift_stb));

endmodule

bind spi_word_shifter spi_word_shifter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en     (clk_en),
  .busy       (busy),
  .sclk       (sclk),
  .mosi       (mosi),
  .tx_pop     (tx_pop),
  .tx_valid   (tx_valid),
  .rx_push    (rx_push),
  .word_done  (word_done),
  .cs_o       (cs_o),
  .tx_en      (cfg_q.tx_en),
  .rx_en      (cfg_q.rx_en),
  .cs_invert  (cfg_q.cs_invert),
  .idle_lvl   (idle_lvl),
  .sample_stb (sample_stb),
  .shift_stb  (shift_stb)
);

// File: tb/test_spi_word_shifter.sv
module test_spi_word_shifter;
  import spi_shift_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clk_en = 1'b0;
  logic              go = 1'b0;
  logic [CMD_W-1:0]  cmd = '0;
  logic              tx_valid = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic              miso = 1'b0;
  logic              tx_pop, rx_push, sclk, mosi, busy, word_done;
  logic [DATA_W-1:0] rx_data;
  logic [NUM_CS-1:0] cs_o;

  int n_tests = 0;
  int n_fail  = 0;
  int div     = 1;
  int divcnt  = 0;

  always #4 clk = ~clk;

  spi_word_shifter i_spi_word_shifter (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .go(go), .cmd_word(cmd),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop), .miso(miso),
    .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .cs_o(cs_o), .busy(busy), .word_done(word_done)
  );

  always @(negedge clk) begin
    if (divcnt >= div - 1) begin divcnt = 0; clk_en = 1'b1; end
    else begin divcnt = divcnt + 1; clk_en = 1'b0; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [NUM_CS-1:0] cs_expect(input shift_cfg_t c, input bit active);
    logic [NUM_CS-1:0] rest = c.cs_invert ? '0 : '1;
    bit on = c.cs_hw ? active : c.cs_level;
    if (c.cs_sel_en && on) rest[c.cs_index] = c.cs_invert;
    return rest;
  endfunction

  task automatic apply_cmd(input shift_cfg_t c);
    @(negedge clk);
    cmd = c;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_word(input logic [31:0] txd, input logic [31:0] rpat, input bit timed);
    shift_cfg_t c = cmd;
    int n = int'(c.len_m1) + 1;
    logic [31:0] mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    logic [31:0] mosi_w = '0;
    logic [31:0] push_d = '0;
    logic prev;
    int bits = 0, edges = 0, cycles = 0, pushes = 0;
    bit done = 0, pop_seen;
    @(negedge clk);
    tx_data = txd; tx_valid = c.tx_en; go = 1'b1;
    miso = rpat[n-1];
    prev = sclk;
    #1;
    pop_seen = tx_pop;
    check(pop_seen == c.tx_en, "R7", "pop in start cycle", {31'b0, pop_seen}, {31'b0, c.tx_en});
    @(negedge clk);
    go = 1'b0; tx_valid = 1'b0; cycles = 1;
    check(busy == 1'b1, "R10", "busy after start", {31'b0, busy}, 32'h1);
    check(cs_o == cs_expect(c, 1), "R5", "select during word", {28'b0, cs_o}, {28'b0, cs_expect(c, 1)});
    do begin
      if (sclk !== prev) begin
        edges++;
        if (sclk == !c.smp_fall) begin
          mosi_w = {mosi_w[30:0], mosi};
          bits++;
          if (bits < n) miso = rpat[n-1-bits];
        end
      end
      prev = sclk;
      if (rx_push) begin pushes++; push_d = rx_data; end
      if (word_done) done = 1;
      else begin @(negedge clk); cycles++; end
    end while (!done && cycles < 2000);
    check(done, "R10", "word finished", {31'b0, done}, 32'h1);
    check(mosi_w == (c.tx_en ? (txd & mask) : 32'h0), "R1+R2", "mosi word", mosi_w,
          c.tx_en ? (txd & mask) : 32'h0);
    check(edges == 2 * n, "R11", "edge count", edges, 2 * n);
    check(pushes == (c.rx_en ? 1 : 0), "R8", "push count", pushes, c.rx_en ? 1 : 0);
    if (c.rx_en)
      check(push_d == (rpat & mask), "R8", "received word", push_d, rpat & mask);
    if (timed)
      check(cycles == 2 * n + 1, "R10", "word duration", cycles, 2 * n + 1);
    check(sclk == (c.idle_code == 2'd1 || c.idle_code == 2'd3), "R3", "sclk at rest", {31'b0, sclk},
          {31'b0, (c.idle_code == 2'd1 || c.idle_code == 2'd3)});
    check(busy == 1'b0, "R10", "idle at done", {31'b0, busy}, 32'h0);
    check(cs_o == cs_expect(c, 0), "R6", "select after word", {28'b0, cs_o}, {28'b0, cs_expect(c, 0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    shift_cfg_t c;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(sclk == 1'b0, "R9", "sclk reset", {31'b0, sclk}, 32'h0);
    check(cs_o == 4'hF, "R9", "cs reset", {28'b0, cs_o}, 32'hF);
    check(!busy && !word_done && !tx_pop && !rx_push, "R9", "flags reset",
          {28'b0, busy, word_done, tx_pop, rx_push}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: resting clock codes
    for (int k = 0; k < 4; k++) begin
      c = '0; c.idle_code = 2'(k);
      apply_cmd(c);
      check(sclk == k[0], "R3", "resting code", {31'b0, sclk}, {31'b0, k[0]});
    end

    // R5 R6 R4: software-driven select
    c = '0; c.cs_sel_en = 1'b1; c.cs_index = 2'd2; c.cs_level = 1'b1;
    apply_cmd(c);
    check(cs_o == 4'b1011, "R5", "sw select asserted", {28'b0, cs_o}, 32'hB);
    c.cs_invert = 1'b1;
    apply_cmd(c);
    check(cs_o == 4'b0100, "R6", "inverted select", {28'b0, cs_o}, 32'h4);
    c.cs_level = 1'b0;
    apply_cmd(c);
    check(cs_o == 4'b0000, "R6", "inverted released", {28'b0, cs_o}, 32'h0);
    c.cs_invert = 1'b0; c.cs_level = 1'b1; c.cs_sel_en = 1'b0;
    apply_cmd(c);
    check(cs_o == 4'hF, "R4", "no line enabled", {28'b0, cs_o}, 32'hF);

    // Sweep of lengths, edge modes, rest codes, selects and tick rates
    for (int m = 0; m < 4; m++) begin
      for (int len = 1; len <= 32; len++) begin
        c = '0;
        c.len_m1    = 5'(len - 1);
        c.smp_fall  = m[0];
        c.idle_code = {len[0], m[1]};
        c.tx_en     = 1'b1;
        c.rx_en     = 1'b1;
        c.cs_hw     = 1'b1;
        c.cs_invert = m[0] ^ m[1];
        c.cs_sel_en = 1'b1;
        c.cs_index  = 2'(len % 4);
        div = (len % 3) + 1;
        apply_cmd(c);
        run_word(32'h9E37_79B9 * 32'(len) ^ 32'(m), ~(32'h7F4A_7C15 * 32'(len + m)), div == 1);
      end
    end
    div = 1;

    // R7: transmit disabled, receive enabled
    c = '0; c.len_m1 = 5'd11; c.rx_en = 1'b1; c.cs_hw = 1'b1; c.cs_sel_en = 1'b1;
    apply_cmd(c);
    run_word(32'hFFFF_FFFF, 32'h0000_0A5C, 1'b1);

    // R8: receive disabled
    c = '0; c.len_m1 = 5'd7; c.tx_en = 1'b1; c.smp_fall = 1'b1;
    apply_cmd(c);
    run_word(32'h0000_00C3, 32'h0000_005A, 1'b1);

    // R5: software select held through a word
    c = '0; c.len_m1 = 5'd3; c.tx_en = 1'b1; c.rx_en = 1'b1;
    c.cs_sel_en = 1'b1; c.cs_index = 2'd1; c.cs_level = 1'b1;
    apply_cmd(c);
    run_word(32'h0000_0009, 32'h0000_0006, 1'b1);

    // R7: no start without an upstream word
    c = '0; c.len_m1 = 5'd7; c.tx_en = 1'b1;
    apply_cmd(c);
    go = 1'b1; tx_valid = 1'b0;
    begin
      bit seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (busy || tx_pop) seen = 1;
      end
      check(!seen, "R7", "stall without tx word", {31'b0, seen}, 32'h0);
    end
    go = 1'b0;
    repeat (2) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule